// File: doc/BRIEF.md
# Four-Port GPIO Bank with Edge Interrupts

This block holds four 8-bit general-purpose I/O ports behind a small register bus. For each port it keeps an output data byte, a per-pin interrupt mask and a 2-bit port setting. The port setting picks how the pads are driven and which edge direction counts as an event. The block outputs only the digital pad controls: output data, output enable and pull-up enable. It does not model pad current or resistance.

Every pad input passes through a two-flop synchronizer. Reads of a data-port address return these synchronized levels, not the stored output byte. An enabled pin that makes an edge of its port's selected direction sets one shared pending interrupt flag. This flag stays set until software pulses an acknowledge.

The register bus is a plain single-cycle control path with no back-pressure. A write completes on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` and is valid in the same cycle. No valid/ready handshake is used, because the bus carries no stream data.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every output data bit is 1, every pull-up enable is 1, every output enable is 0, and `irq` is 0.
- R2: A write to address p (0 to 3) stores `bus_wdata` as port p's output byte. Bit i of that byte drives `pad_dout[8p+i]`.
- R3: A read of address p (0 to 3) returns port p's pad levels after two-flop synchronization. A pad change made between clock edges is visible after the second following rising edge and not after the first.
- R4: A read of any address other than 0 to 3 returns 0. This includes the write-only mask registers and the configuration register.
- R5: A write to address 8 sets the configuration. Bits [2p+1:2p] form port p's field. A field with bit 1 = 0 selects pull-up input: pull-up on and output enable off. Field 10 selects open-drain: pull-up off, and the output is enabled only where the data bit is 0. Field 11 selects push-pull: pull-up off and output enabled on all pins.
- R6: Bit 0 of port p's field selects the edge direction. A value of 1 selects a rising edge (0 to 1), and a value of 0 selects a falling edge (1 to 0). An edge in the other direction raises no interrupt.
- R7: A write to address 4+p sets port p's interrupt mask, with bit i enabling pin i. An edge on a pin whose mask bit is 0 never sets `irq`.
- R8: A qualifying edge on any enabled pin of any port sets the single `irq` flag. The flag rises after the third rising clock edge following the pad change.
- R9: An `irq_ack` pulse in a cycle with no qualifying edge clears `irq` on the next clock edge.
- R10: If a qualifying edge is detected in the same cycle as `irq_ack`, `irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 32 | Raw pad input levels, port p at bits [8p+7:8p] |
| pad_dout | output | 32 | Output data to pads |
| pad_oe | output | 32 | Output driver enable per pin |
| pad_pu | output | 32 | Pull-up enable per pin |
| irq | output | 1 | Shared pending GPIO interrupt |
| irq_ack | input | 1 | Acknowledge pulse that clears `irq` |

## Verification
The synchronizer and previous-sample registers can hold a wrong value. This shows up as a spurious or missing `irq` three cycles after a pad change, or as read data that shows a change one cycle too early or too late. Corrupted mask or configuration state shows up directly on `pad_oe`/`pad_pu` in the same cycle. It also shows up as edge decisions that go the wrong way on the next pad toggle. A faulty pending flag shows up within one cycle of an acknowledge: it either fails to clear, or it drops an edge that arrived together with the acknowledge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Per-port 2-bit configuration field
  typedef enum logic [1:0] {
    CFG_PU_FALL = 2'b00,
    CFG_PU_RISE = 2'b01,
    CFG_OD_FALL = 2'b10,
    CFG_PP_RISE = 2'b11
  } port_cfg_e;

  function automatic logic cfg_rising(input logic [1:0] c);
    return c[0];
  endfunction

  function automatic logic cfg_is_input(input logic [1:0] c);
    return ~c[1];
  endfunction

  function automatic logic cfg_is_push_pull(input logic [1:0] c);
    return (c == CFG_PP_RISE);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // Reset to 1 so that an idle pulled-up pad does not look like an edge
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b1;
        sync_q[i] <= 1'b1;
      end else begin
        meta_q[i] <= d_async[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [PORT_W-1:0]           bus_wdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_sync,
  output logic [PORT_W-1:0]           bus_rdata,
  output logic [NUM_PORTS*PORT_W-1:0] data_q,
  output logic [NUM_PORTS*PORT_W-1:0] en_q,
  output logic [2*NUM_PORTS-1:0]      cfg_q
);
  localparam int EN_BASE  = NUM_PORTS;
  localparam int CFG_ADDR = 2 * NUM_PORTS;
  localparam int CFG_W    = 2 * NUM_PORTS;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[p*PORT_W +: PORT_W] <= '1;
      end else if (bus_wr && bus_addr == ADDR_W'(p)) begin
        data_q[p*PORT_W +: PORT_W] <= bus_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[p*PORT_W +: PORT_W] <= '0;
      end else if (bus_wr && bus_addr == ADDR_W'(EN_BASE + p)) begin
        en_q[p*PORT_W +: PORT_W] <= bus_wdata;
      end
    end
  end

  // Config field must fit the data width (CFG_W <= PORT_W)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (bus_wr && bus_addr == ADDR_W'(CFG_ADDR)) begin
      cfg_q <= bus_wdata[CFG_W-1:0];
    end
  end

  // Only data-port addresses return anything; write-only slots read 0
  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == ADDR_W'(p)) begin
        bus_rdata = pin_sync[p*PORT_W +: PORT_W];
      end
    end
  end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_sync,
  input  logic [NUM_PORTS*PORT_W-1:0] en_q,
  input  logic [2*NUM_PORTS-1:0]      cfg_q,
  output logic                        hit_any
);
  localparam int PINS = NUM_PORTS * PORT_W;

  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= pin_sync;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] cur, old, rise, fall;
    assign cur  = pin_sync[p*PORT_W +: PORT_W];
    assign old  = prev_q[p*PORT_W +: PORT_W];
    assign rise = cur & ~old;
    assign fall = ~cur & old;
    assign hit[p*PORT_W +: PORT_W] =
      (cfg_rising(cfg_q[2*p +: 2]) ? rise : fall) & en_q[p*PORT_W +: PORT_W];
  end

  assign hit_any = |hit;
endmodule

// File: rtl/gpio_irq_pend.sv
module gpio_irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ack,
  output logic pend
);
  // Set wins over acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_evt) pend <= 1'b1;
    else if (ack)     pend <= 1'b0;
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8
) (
  input  logic [NUM_PORTS*PORT_W-1:0] data_q,
  input  logic [2*NUM_PORTS-1:0]      cfg_q,
  output logic [NUM_PORTS*PORT_W-1:0] pad_dout,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
  output logic [NUM_PORTS*PORT_W-1:0] pad_pu
);
  assign pad_dout = data_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [1:0] c;
    assign c = cfg_q[2*p +: 2];
    always_comb begin
      if (cfg_is_input(c)) begin
        pad_pu[p*PORT_W +: PORT_W] = '1;
        pad_oe[p*PORT_W +: PORT_W] = '0;
      end else if (cfg_is_push_pull(c)) begin
        pad_pu[p*PORT_W +: PORT_W] = '0;
        pad_oe[p*PORT_W +: PORT_W] = '1;
      end else begin
        pad_pu[p*PORT_W +: PORT_W] = '0;
        pad_oe[p*PORT_W +: PORT_W] = ~data_q[p*PORT_W +: PORT_W];
      end
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 8,
  localparam int PINS     = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_dout,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pu,
  output logic              irq,
  input  logic              irq_ack
);
  logic [PINS-1:0]        pin_sync;
  logic [PINS-1:0]        data_q;
  logic [PINS-1:0]        en_q;
  logic [2*NUM_PORTS-1:0] cfg_q;
  logic                   hit_any;

  gpio_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .d_sync(pin_sync)
  );

  gpio_regfile #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pin_sync(pin_sync), .bus_rdata(bus_rdata),
    .data_q(data_q), .en_q(en_q), .cfg_q(cfg_q)
  );

  gpio_edge_det #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .en_q(en_q),
    .cfg_q(cfg_q), .hit_any(hit_any)
  );

  gpio_irq_pend u_pend (
    .clk(clk), .rst_n(rst_n), .set_evt(hit_any), .ack(irq_ack), .pend(irq)
  );

  gpio_pad_ctrl #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_pad (
    .data_q(data_q), .cfg_q(cfg_q), .pad_dout(pad_dout),
    .pad_oe(pad_oe), .pad_pu(pad_pu)
  );
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [PORT_W-1:0]           bus_rdata,
  input logic                        irq,
  input logic                        irq_ack,
  input logic                        hit_any,
  input logic [NUM_PORTS*PORT_W-1:0] en_q,
  input logic [NUM_PORTS*PORT_W-1:0] pad_pu,
  input logic [NUM_PORTS*PORT_W-1:0] pad_oe
);
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(NUM_PORTS)) |-> (bus_rdata == '0)); // R4

  AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_oe) == '0)); // R5

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !hit_any); // R7

  AST_HIT_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |=> irq); // R8

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hit_any)); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !hit_any) |=> !irq); // R9

  AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && hit_any) |=> irq); // R10
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq(irq), .irq_ack(irq_ack), .hit_any(hit_any), .en_q(en_q),
  .pad_pu(pad_pu), .pad_oe(pad_oe)
);

// File: tb/gpio_edge_bank_tb.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] pad_in = '1;
  logic [31:0] pad_dout, pad_oe, pad_pu;
  logic        irq;
  logic        irq_ack = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  gpio_edge_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_dout(pad_dout), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .irq(irq), .irq_ack(irq_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ack_pulse();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  // Expected interrupt from one pad change, per R6/R7/R8
  function automatic logic exp_irq(input logic [7:0] cfg, input logic [31:0] en,
                                   input logic [31:0] oldp, input logic [31:0] newp);
    logic any = 1'b0;
    for (int p = 0; p < 4; p++) begin
      logic [7:0] o = oldp[8*p +: 8];
      logic [7:0] n = newp[8*p +: 8];
      logic [7:0] d = cfg[2*p] ? (~o & n) : (o & ~n);
      any |= |(d & en[8*p +: 8]);
    end
    return any;
  endfunction

  // Expected pad controls, per R5
  function automatic logic [63:0] exp_pads(input logic [7:0] cfg, input logic [31:0] data);
    logic [31:0] oe, pu;
    for (int p = 0; p < 4; p++) begin
      logic [1:0] c = cfg[2*p +: 2];
      if (!c[1])        begin pu[8*p +: 8] = '1; oe[8*p +: 8] = '0; end
      else if (c[0])    begin pu[8*p +: 8] = '0; oe[8*p +: 8] = '1; end
      else              begin pu[8*p +: 8] = '0; oe[8*p +: 8] = ~data[8*p +: 8]; end
    end
    return {oe, pu};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [7:0]  cfg;
    logic [31:0] en, data, oldp, newp;
    logic [63:0] pe;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dout", pad_dout, 32'hFFFF_FFFF);
    check("R1 pu", pad_pu, 32'hFFFF_FFFF);
    check("R1 oe", pad_oe, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 + R5 push-pull on port 2
    wr(8'h02, 8'h5A);
    wr(8'h08, 8'h30);
    #1;
    check("R2 dout port2", {24'b0, pad_dout[23:16]}, 32'h5A);
    check("R5 push-pull oe", {24'b0, pad_oe[23:16]}, 32'hFF);
    check("R5 push-pull pu", {24'b0, pad_pu[23:16]}, 32'h00);
    // R5 open-drain on port 0
    wr(8'h00, 8'h0F);
    wr(8'h08, 8'h02);
    #1;
    check("R5 open-drain oe", {24'b0, pad_oe[7:0]}, 32'hF0);
    check("R5 open-drain pu", {24'b0, pad_pu[7:0]}, 32'h00);
    check("R5 input pu port2", {24'b0, pad_pu[23:16]}, 32'hFF);

    // R4 write-only and unused addresses
    wr(8'h05, 8'hAA);
    for (int a = 4; a <= 9; a++) begin
      rd(8'(a), r);
      check("R4 read zero", {24'b0, r}, 32'h0);
    end
    rd(8'hFF, r);
    check("R4 read zero high", {24'b0, r}, 32'h0);
    wr(8'h05, 8'h00);
    wr(8'h08, 8'h00);

    // R3 synchronizer latency on port 1
    @(negedge clk); pad_in[15:8] = 8'h3C;
    @(negedge clk); bus_addr = 8'h01; #1 r = bus_rdata;
    check("R3 not yet", {24'b0, r}, 32'hFF);
    @(negedge clk); #1 r = bus_rdata;
    check("R3 visible", {24'b0, r}, 32'h3C);
    repeat (3) @(negedge clk);
    pad_in[15:8] = 8'hFF;
    repeat (4) @(negedge clk);
    ack_pulse();

    // R7 masked pin: only pin 0 of port 1 enabled, falling edge on pin 1
    wr(8'h05, 8'h01);
    @(negedge clk); pad_in[9] = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 masked pin", {31'b0, irq}, 32'h0);
    pad_in[9] = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'h05, 8'h00);

    // R6 wrong direction on port 3 pin 7 (rising selected)
    wr(8'h08, 8'h40);
    wr(8'h07, 8'h80);
    @(negedge clk); pad_in[31] = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 falling ignored", {31'b0, irq}, 32'h0);
    // R8 timing of rising edge
    pad_in[31] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 irq not early", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq set", {31'b0, irq}, 32'h1);

    // R10 edge coinciding with acknowledge
    wr(8'h04, 8'h01);
    @(negedge clk); pad_in[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R10 edge keeps irq", {31'b0, irq}, 32'h1);
    // R9 plain acknowledge
    ack_pulse();
    check("R9 ack clears", {31'b0, irq}, 32'h0);
    pad_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    ack_pulse();

    // Random mix
    oldp = pad_in;
    for (int it = 0; it < 60; it++) begin
      cfg  = 8'($urandom());
      en   = $urandom();
      data = $urandom();
      wr(8'h08, cfg);
      for (int p = 0; p < 4; p++) begin
        wr(8'(4 + p), en[8*p +: 8]);
        wr(8'(p), data[8*p +: 8]);
      end
      pe = exp_pads(cfg, data);
      #1;
      check("R2 random dout", pad_dout, data);
      check("R5 random oe", pad_oe, pe[63:32]);
      check("R5 random pu", pad_pu, pe[31:0]);
      ack_pulse();
      check("R9 random clear", {31'b0, irq}, 32'h0);
      newp = $urandom();
      @(negedge clk); pad_in = newp;
      repeat (4) @(negedge clk);
      check("R8 R6 R7 random irq", {31'b0, irq}, {31'b0, exp_irq(cfg, en, oldp, newp)});
      for (int p = 0; p < 4; p++) begin
        rd(8'(p), r);
        check("R3 random read", {24'b0, r}, {24'b0, newp[8*p +: 8]});
      end
      oldp = newp;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule